// File: doc/BRIEF.md
# Sparse Vector Scatter and Threshold Scanner

This block drives a working memory of small saturating-free counters, one word per location, where each word also carries a single tag bit that marks its contents as valid (tag set) or free to be overwritten (tag clear). The memory itself sits outside the block behind a single-port synchronous RAM interface with one cycle of read latency. The block runs one command at a time, and each command streams one memory access per cycle whenever it can.

A sparse bit vector reaches the block as a list of the integer positions of its set bits, for example positions 8, 1 and 0 for a vector whose only set bits are those three. A command carries a small header: an element count, the lowest and highest set-bit positions, and a threshold. A clear pass zeroes every word and drops every tag. A move pass consumes exactly the given number of positions from the index stream and writes a tagged count of one at each position. A scan pass reads the words from the header's lowest to highest position and places the address of every tagged word whose count is strictly above the threshold into a small output FIFO, which then drains through a valid/ready stream.

Top module: `svec_scan_unit`

## Requirements
- R1: While reset is held and after its release, `cmd_ready` is 1 and `out_valid`, `in_ready`, `mem_en` and `range_err` are 0.
- R2: A command with `cmd_op` = 0 (clear) writes the word 0 to every location from address 0 upward, one per cycle, and holds `cmd_ready` low for exactly DEPTH cycles.
- R3: A command with `cmd_op` = 1 (move) accepts exactly `cmd_len` indices and writes, at each in-range index, a word whose bit CNT_W (the tag) is 1 and whose low CNT_W bits (the count) are 1; with `cmd_len` = 0 it ends at once without taking an index.
- R4: A move index at or above DEPTH writes nothing and sets `range_err`, which stays set until the next clear command is accepted.
- R5: A command with `cmd_op` = 2 (scan) emits, in ascending order, the address of every location in the window whose tag is 1 and whose count is greater than `cmd_thresh`, and nothing else.
- R6: A location whose tag is 0 is never emitted, whatever its count.
- R7: The scan window runs from `cmd_lo` to `cmd_hi` inclusive, with `cmd_hi` clipped to DEPTH-1; a window with `cmd_lo` above `cmd_hi` or `cmd_lo` at or above DEPTH emits nothing and ends at once.
- R8: When `out_ready` is low the scan stalls without losing or duplicating any address, and `out_index` stays unchanged while `out_valid` is high and `out_ready` is low.
- R9: A command presented while `cmd_ready` is low has no effect, and `in_ready` is high only during a move pass.
- R10: A scan over N locations with `out_ready` held high keeps `cmd_ready` low for exactly N+2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken on this cycle if valid |
| cmd_op | input | 2 | 0 clear, 1 move, 2 scan, 3 no operation |
| cmd_len | input | IDX_W | Number of indices a move consumes |
| cmd_lo | input | IDX_W | Lowest position of the scan window |
| cmd_hi | input | IDX_W | Highest position of the scan window |
| cmd_thresh | input | CNT_W | Scan emits counts strictly above this |
| in_valid | input | 1 | Index stream valid |
| in_ready | output | 1 | Index stream ready |
| in_index | input | IDX_W | Set-bit position |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | CNT_W+1 | RAM write word, tag in the top bit |
| mem_rdata | input | CNT_W+1 | RAM read word, one cycle after the read |
| out_valid | output | 1 | Output address present |
| out_ready | input | 1 | Output consumer ready |
| out_index | output | ADDR_W | Address of a location above threshold |
| range_err | output | 1 | Sticky flag for a dropped move index |

## Verification
The bench preloads the external RAM with counts that straddle the threshold and with tags cleared on some words, so a design that ignored the tag or compared with greater-or-equal would emit extra addresses that the scoreboard flags as unexpected. Windows that are inverted, start past the end, or end past the end probe the clipping; a design that wrapped the address or missed the inclusive top word would emit wrong or missing addresses. Throttling `out_ready` forces the FIFO full while reads are in flight, where a design that issued reads without counting the one in flight would drop an address, and a changing `out_index` during a stall is caught directly. A move list with an out-of-range index and a zero-length move check that nothing aliases into the memory and that the pass length is counted exactly.

// File: rtl/svec_pkg.sv
package svec_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_MOVE  = 2'd1,
    OP_SCAN  = 2'd2,
    OP_NONE  = 2'd3
  } svec_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_MOVE  = 2'd2,
    ST_SCAN  = 2'd3
  } svec_state_e;

endpackage

// File: rtl/svec_rst_sync.sv
module svec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= 1'b0;
        else         sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/svec_fifo.sv
module svec_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [LVL_W-1:0] level
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic             pop;

  assign out_valid = (cnt_q != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = slot_q[rd_q];
  assign level     = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST_P) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST_P) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= push_data;
  end

  // R8: a push never lands on a full queue unless a pop frees a slot
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((cnt_q < LVL_W'(DEPTH)) || pop));

  // R8: a stalled head entry stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/svec_scan_cmp.sv
module svec_scan_cmp #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              rd_pend,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W:0]    rd_word,
  input  logic [CNT_W-1:0]  thr,
  output logic              push,
  output logic [ADDR_W-1:0] push_addr
);

  logic             tag_ok;
  logic [CNT_W-1:0] cnt;

  assign tag_ok    = rd_word[CNT_W];
  assign cnt       = rd_word[CNT_W-1:0];
  assign push      = rd_pend && tag_ok && (cnt > thr);
  assign push_addr = rd_addr;

endmodule

// File: rtl/svec_ctrl.sv
module svec_ctrl
  import svec_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 12,
  parameter int CNT_W      = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_len,
  input  logic [IDX_W-1:0]  cmd_lo,
  input  logic [IDX_W-1:0]  cmd_hi,
  input  logic [CNT_W-1:0]  cmd_thresh,
  output logic              cmd_ready,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_index,
  output logic              in_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W:0]    mem_wdata,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              rd_pend,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  thr,
  output logic              range_err
);

  localparam logic [ADDR_W-1:0] LAST_A  = {ADDR_W{1'b1}};
  localparam logic [CNT_W:0]    MOVE_WD = {1'b1, CNT_W'(1)};
  localparam logic [LVL_W:0]    FDEPTH  = (LVL_W+1)'(FIFO_DEPTH);

  svec_state_e       state_q, state_d;
  svec_op_e          op;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0]  thr_q, thr_d;
  logic [IDX_W-1:0]  rem_q, rem_d;
  logic              err_q, err_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              fin_q, fin_d;

  logic              in_range, lo_ok, hi_ok, scan_empty, room;
  logic [ADDR_W-1:0] hi_eff;
  logic              cfg_en;

  assign op         = svec_op_e'(cmd_op);
  assign in_range   = (in_index[IDX_W-1:ADDR_W] == '0);
  assign lo_ok      = (cmd_lo[IDX_W-1:ADDR_W] == '0);
  assign hi_ok      = (cmd_hi[IDX_W-1:ADDR_W] == '0);
  assign hi_eff     = hi_ok ? cmd_hi[ADDR_W-1:0] : LAST_A;
  assign scan_empty = !lo_ok || (cmd_lo > cmd_hi);
  assign room       = ({1'b0, fifo_level} + (LVL_W+1)'(pend_q)) < FDEPTH;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    hi_d      = hi_q;
    thr_d     = thr_q;
    rem_d     = rem_q;
    err_d     = err_q;
    pend_d    = 1'b0;
    fin_d     = fin_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = '0;
    in_ready  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          unique case (op)
            OP_CLEAR: begin
              state_d = ST_CLEAR;
              addr_d  = '0;
              err_d   = 1'b0;
            end
            OP_MOVE: begin
              if (cmd_len != '0) begin
                state_d = ST_MOVE;
                rem_d   = cmd_len;
              end
            end
            OP_SCAN: begin
              if (!scan_empty) begin
                state_d = ST_SCAN;
                addr_d  = cmd_lo[ADDR_W-1:0];
                hi_d    = hi_eff;
                thr_d   = cmd_thresh;
                fin_d   = 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
      ST_CLEAR: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        if (addr_q == LAST_A) state_d = ST_IDLE;
        else                  addr_d  = addr_q + 1'b1;
      end
      ST_MOVE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (in_range) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = in_index[ADDR_W-1:0];
            mem_wdata = MOVE_WD;
          end else begin
            err_d = 1'b1;
          end
          rem_d = rem_q - 1'b1;
          if (rem_q == IDX_W'(1)) state_d = ST_IDLE;
        end
      end
      ST_SCAN: begin
        if (!fin_q && room) begin
          mem_en = 1'b1;
          pend_d = 1'b1;
          if (addr_q == hi_q) fin_d  = 1'b1;
          else                addr_d = addr_q + 1'b1;
        end else if (fin_q && !pend_q) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cfg_en = (state_q == ST_IDLE) && cmd_valid && (op == OP_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      err_q   <= err_d;
      pend_q  <= pend_d;
      fin_q   <= fin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      thr_q <= '0;
    end else if (cfg_en) begin
      hi_q  <= hi_d;
      thr_q <= thr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_addr_q <= '0;
    else if (pend_d) pend_addr_q <= addr_q;
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign rd_pend   = pend_q;
  assign rd_addr   = pend_addr_q;
  assign thr       = thr_q;
  assign range_err = err_q;

  // R2: consecutive clear writes step the address upward by one
  a_r2_clear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR && $past(state_q == ST_CLEAR)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R3: taking the last index of a move returns the block to idle
  a_r3_len_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rem_q == IDX_W'(1)) |=> cmd_ready);

  // R4: an out-of-range index leaves the error flag set
  a_r4_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_range) |=> range_err);

  // R7: every read in flight lies inside the clipped window
  a_r7_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> (rd_addr <= hi_q));

  // R9: an idle block neither touches memory nor takes indices
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_en && !in_ready));

endmodule

// File: rtl/svec_scan_unit.sv
module svec_scan_unit #(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 12,
  parameter int CNT_W       = 4,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_len,
  input  logic [IDX_W-1:0]  cmd_lo,
  input  logic [IDX_W-1:0]  cmd_hi,
  input  logic [CNT_W-1:0]  cmd_thresh,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_index,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W:0]    mem_wdata,
  input  logic [CNT_W:0]    mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_index,
  output logic              range_err
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic              srst_n;
  logic [LVL_W-1:0]  fifo_level;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  thr;
  logic              push;
  logic [ADDR_W-1:0] push_addr;

  svec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  svec_ctrl #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_len    (cmd_len),
    .cmd_lo     (cmd_lo),
    .cmd_hi     (cmd_hi),
    .cmd_thresh (cmd_thresh),
    .cmd_ready  (cmd_ready),
    .in_valid   (in_valid),
    .in_index   (in_index),
    .in_ready   (in_ready),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .fifo_level (fifo_level),
    .rd_pend    (rd_pend),
    .rd_addr    (rd_addr),
    .thr        (thr),
    .range_err  (range_err)
  );

  svec_scan_cmp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_cmp (
    .rd_pend   (rd_pend),
    .rd_addr   (rd_addr),
    .rd_word   (mem_rdata),
    .thr       (thr),
    .push      (push),
    .push_addr (push_addr)
  );

  svec_fifo #(
    .W     (ADDR_W),
    .DEPTH (FIFO_DEPTH),
    .LVL_W (LVL_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (srst_n),
    .push      (push),
    .push_data (push_addr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_index),
    .level     (fifo_level)
  );

  // R6: an address reaches the queue only from a tagged word
  a_r6_tag_only: assert property (@(posedge clk) disable iff (!srst_n)
    push |-> mem_rdata[CNT_W]);

endmodule

// File: tb/svec_scan_unit_tb_top.sv
module svec_scan_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 12;
  localparam int CNT_W  = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WW     = CNT_W + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid, cmd_ready;
  logic [1:0]        cmd_op;
  logic [IDX_W-1:0]  cmd_len, cmd_lo, cmd_hi;
  logic [CNT_W-1:0]  cmd_thresh;
  logic              in_valid, in_ready;
  logic [IDX_W-1:0]  in_index;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [WW-1:0]     mem_wdata, mem_rdata;
  logic              out_valid, out_ready, range_err;
  logic [ADDR_W-1:0] out_index;

  logic [WW-1:0]     ram [DEPTH];
  logic              bd_we;
  logic [ADDR_W-1:0] bd_addr;
  logic [WW-1:0]     bd_data;

  int    checks = 0;
  int    errors = 0;
  int    exp_q[$];
  string cur_req = "R5";
  bit    bp_mode = 1'b0;
  int    bp_cnt  = 0;
  bit    mon_on  = 1'b0;
  bit    stall_prev = 1'b0;
  logic [ADDR_W-1:0] stall_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  svec_scan_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .FIFO_DEPTH(4), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_thresh(cmd_thresh),
    .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index), .range_err(range_err)
  );

  // external RAM model with a backdoor load port
  always @(posedge clk) begin
    if (bd_we) ram[bd_addr] <= bd_data;
    else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  always @(negedge clk) begin
    bp_cnt++;
    out_ready <= bp_mode ? (bp_cnt % 3 == 0) : 1'b1;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (stall_prev) begin
        chk("R8 hold", out_valid && (out_index == stall_idx), int'(out_index), int'(stall_idx));
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk({cur_req, " unexpected"}, 1'b0, int'(out_index), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cur_req, int'(out_index) == e, int'(out_index), e);
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_idx  = out_index;
    end
  end

  task automatic send_cmd(input logic [1:0] op, input int len, input int lo, input int hi, input int thr);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_len = IDX_W'(len);
    cmd_lo = IDX_W'(lo); cmd_hi = IDX_W'(hi); cmd_thresh = CNT_W'(thr);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
  endtask

  task automatic preload(input int seed, input bit all_untagged);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      bd_we = 1'b1; bd_addr = ADDR_W'(a);
      if (all_untagged) bd_data = {1'b0, 4'hF};
      else bd_data = {((a + seed) % 5) != 0, 4'((a * 7 + seed) % 16)};
    end
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic do_clear(output int busy);
    send_cmd(2'd0, 0, 0, 0, 0);
    wait_idle(busy);
  endtask

  task automatic run_scan(input string req, input int lo, input int hi, input int thr, output int busy);
    int k;
    cur_req = req;
    for (int a = lo; a <= hi && a < DEPTH; a++)
      if (ram[a][CNT_W] && (int'(ram[a][CNT_W-1:0]) > thr)) exp_q.push_back(a);
    send_cmd(2'd2, 0, lo, hi, thr);
    wait_idle(busy);
    k = 0;
    while ((exp_q.size() != 0 || out_valid) && k < 3000) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
    chk({req, " all emitted"}, exp_q.size() == 0, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int busy, bad;
    bit set_b [DEPTH];
    int mv [7] = '{5, 300, 17, 255, 5, 0, 128};
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_len = '0; cmd_lo = '0; cmd_hi = '0;
    cmd_thresh = '0; in_valid = 1'b0; in_index = '0; bd_we = 1'b0; bd_addr = '0; bd_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", cmd_ready && !out_valid && !in_ready && !mem_en && !range_err,
        {cmd_ready, out_valid, in_ready, mem_en, range_err}, 5'b10000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", cmd_ready && !out_valid && !in_ready && !mem_en && !range_err,
        {cmd_ready, out_valid, in_ready, mem_en, range_err}, 5'b10000);
    mon_on = 1'b1;

    // R2 clear over a dirty memory, with a stray command while busy (R9)
    preload(1, 1'b0);
    send_cmd(2'd0, 0, 0, 0, 0);
    busy = 0;
    while (!cmd_ready) begin
      cmd_valid = (busy == 5); cmd_op = 2'd1; cmd_len = IDX_W'(3);
      busy++; @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R2 clear busy cycles", busy == DEPTH, busy, DEPTH);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) if (ram[a] != '0) bad++;
    chk("R2 memory zeroed", bad == 0, bad, 0);
    @(negedge clk);
    chk("R9 stray command ignored", cmd_ready && !in_ready, {cmd_ready, in_ready}, 2'b10);

    // R3 / R4 move with duplicates and an out-of-range index
    for (int a = 0; a < DEPTH; a++) set_b[a] = 1'b0;
    send_cmd(2'd1, 7, 0, 0, 0);
    foreach (mv[i]) begin
      in_valid = 1'b1; in_index = IDX_W'(mv[i]);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (mv[i] < DEPTH) set_b[mv[i]] = 1'b1;
    end
    in_valid = 1'b0;
    chk("R3 exact length ends pass", cmd_ready && !in_ready, {cmd_ready, in_ready}, 2'b10);
    bad = 0;
    for (int a = 0; a < DEPTH; a++)
      if (ram[a] != (set_b[a] ? WW'({1'b1, 4'h1}) : WW'(0))) bad++;
    chk("R3 tagged ones written", bad == 0, bad, 0);
    chk("R4 no aliased write", ram[300 % DEPTH] == '0, int'(ram[300 % DEPTH]), 0);
    chk("R4 error flag set", range_err == 1'b1, range_err, 1);

    // R3 zero-length move
    send_cmd(2'd1, 0, 0, 0, 0);
    chk("R3 zero length", cmd_ready && !in_ready, {cmd_ready, in_ready}, 2'b10);
    chk("R4 flag sticky", range_err == 1'b1, range_err, 1);

    // R5 scan of moved data, threshold 0
    run_scan("R5 moved list", 0, DEPTH - 1, 0, busy);

    do_clear(busy);
    chk("R4 flag cleared", range_err == 1'b0, range_err, 0);

    // R5 / R6 / R10 full scan over preloaded counts
    preload(3, 1'b0);
    run_scan("R5 full thr7", 0, DEPTH - 1, 7, busy);
    chk("R10 scan cycles", busy == DEPTH + 2, busy, DEPTH + 2);
    run_scan("R5 thr15 none", 0, DEPTH - 1, 15, busy);

    // R7 windows, R8 backpressure
    bp_mode = 1'b1;
    run_scan("R8 window stall", 10, 40, 0, busy);
    run_scan("R7 clipped hi", 240, 4000, 3, busy);
    bp_mode = 1'b0;
    run_scan("R7 inverted", 50, 20, 0, busy);
    chk("R7 inverted ends at once", busy == 0, busy, 0);
    run_scan("R7 lo past end", 300, 400, 0, busy);
    chk("R7 lo past end ends at once", busy == 0, busy, 0);
    run_scan("R7 single word", 77, 77, 0, busy);

    // R6 untagged words with full counts
    preload(0, 1'b1);
    bp_mode = 1'b1;
    run_scan("R6 untagged", 0, DEPTH - 1, 0, busy);
    bp_mode = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule